// File: doc/BRIEF.md
# Serial Port Register Front End

This block sits between a 32-bit memory-mapped bus and a serial frame engine. Software sees four word registers: control, receive data, transmit data and status. Behind them the block keeps a transmit FIFO and a receive FIFO, two interrupt pending flags, three sticky error flags and one active-high, level-sensitive interrupt line. The frame engine is a separate block. It takes bytes from the transmit FIFO through a ready/pop handshake, pushes received bytes with a strobe, and reports line errors with a single-cycle pulse.

The control register enables the port and the two interrupt sources. It also holds one DMA request enable per direction, the loopback and automatic flow-control enables, and a selector for the status level field. That field shows either the transmit or the receive FIFO fill count. The status register combines write-one-to-clear flags with live FIFO and modem-line state. Reads are combinational on the cycle the read strobe is high. Writes take effect on the clock edge.

Top module: `uart_regif`

## Requirements
- R1: After a synchronous reset, and with `cts_in` and `tx_busy` low, control reads 0x0000_0000, status reads 0x0000_0422 and `irq` and `rts_out` are low. In that status value, bit 1 is transmit pending, bit 5 is receive empty and bit 10 is transmitter idle.
- R2: Control keeps only bits 12 (flow control), 14 (level select), 15 (port enable), 16 (receive DMA), 17 (transmit DMA), 18 (receive interrupt), 19 (transmit interrupt) and 20 (loopback). A write of all ones reads back 0x001F_D000.
- R3: Bits 7:0 written to the transmit data word (offset 0x008) leave on `tx_byte` in write order. `tx_ready` is high when the port is enabled and the FIFO is not empty, and a `tx_pop` while `tx_ready` is high removes the head.
- R4: A read of the receive data word (offset 0x004) returns the oldest byte in bits 7:0 with zeros above and pops it. A read while the FIFO is empty returns 0 and changes nothing.
- R5: Status (offset 0x00C) bits 16:11 hold the transmit FIFO count when control bit 14 is 1 and the receive count when it is 0. Bit 5 is receive empty, bit 6 is transmit full, bit 17 mirrors `tx_busy`, and bit 10 is set when the transmit FIFO is empty and `tx_busy` is low.
- R6: A transmit data write while the transmit FIFO is full, with no pop in the same cycle, is dropped and sets status bit 3. Writing 1 to bit 3 clears it.
- R7: An `rx_push` while the receive FIFO is full, with no read in the same cycle, drops the byte and sets status bit 2. An `rx_line_err` pulse sets bit 4. Both bits clear on a write of 1. While the port is disabled, `rx_push` and `rx_line_err` are ignored.
- R8: Status bit 0 is set while the receive FIFO is non-empty. Status bit 1 is set while the transmit count is at most half the depth. A write of 1 clears either bit only once its condition is false, and a write of 0 leaves both bits as they are.
- R9: `irq` is high when bit 0 is set and control bit 18 is 1, or when bit 1 is set and control bit 19 is 1.
- R10: Status bit 7 mirrors `cts_in`. With control bit 12 set, `tx_ready` is held low while `cts_in` is low. `rts_out`, mirrored in status bit 8, is high when the port is enabled and either flow control is off or the receive FIFO is not full.
- R11: `loopback_en` follows control bit 20. `rx_dma_req` is control bit 16 AND receive non-empty. `tx_dma_req` is control bit 17 AND transmit not full.
- R12: A push and a pop in the same cycle on a non-empty FIFO, including a full one, both take effect. The count stays the same, order is kept and no error flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; the read data is valid in the same cycle |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| irq | output | 1 | Level interrupt, active high |
| tx_byte | output | 8 | Head of the transmit FIFO |
| tx_ready | output | 1 | A byte may be taken by the engine |
| tx_pop | input | 1 | Engine takes the head byte |
| tx_busy | input | 1 | Engine is shifting a frame |
| rx_byte | input | 8 | Received byte |
| rx_push | input | 1 | Received byte strobe |
| rx_line_err | input | 1 | Parity, framing or break pulse |
| cts_in | input | 1 | Clear-to-send line |
| rts_out | output | 1 | Request-to-send line |
| loopback_en | output | 1 | Engine loopback enable |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |

## Verification
An engine push into the receive FIFO and a bus read of the receive data word can land on the same clock edge, and so can a transmit pop and a transmit data write. The bench fills the receive FIFO to its depth, then raises `rx_push` and the read strobe together. It checks three things: the read returns the oldest byte, the fill count stays at its maximum with no overrun flag, and draining yields the new byte last. A second collision, a write-one-to-clear on a pending flag whose condition still holds, is judged by reading the flag back as still set.

// File: rtl/uart_regif_pkg.sv
// Package: shared register word indices, field positions and widths for the
// serial port register front end. Assumes byte addressing with word registers.
package uart_regif_pkg;
    localparam int unsigned WORD_W   = 32;
    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned LVL_W    = 6;
    localparam int unsigned NFLAG    = 5;

    // Byte offsets of the four registers
    localparam int unsigned OFS_CTRL = 'h000;
    localparam int unsigned OFS_RXD  = 'h004;
    localparam int unsigned OFS_TXD  = 'h008;
    localparam int unsigned OFS_STAT = 'h00C;

    // Control field positions
    localparam int unsigned C_FLOW   = 12;
    localparam int unsigned C_LVLTX  = 14;
    localparam int unsigned C_EN     = 15;
    localparam int unsigned C_RXDMA  = 16;
    localparam int unsigned C_TXDMA  = 17;
    localparam int unsigned C_RXIE   = 18;
    localparam int unsigned C_TXIE   = 19;
    localparam int unsigned C_LOOP   = 20;

    localparam logic [WORD_W-1:0] CTRL_KEEP =
        (32'd1 << C_FLOW) | (32'd1 << C_LVLTX) | (32'd1 << C_EN) |
        (32'd1 << C_RXDMA) | (32'd1 << C_TXDMA) | (32'd1 << C_RXIE) |
        (32'd1 << C_TXIE) | (32'd1 << C_LOOP);

    // Sticky flag slots; slot index equals the status bit position
    typedef enum logic [2:0] {
        FL_RXPEND = 3'd0,
        FL_TXPEND = 3'd1,
        FL_OVR    = 3'd2,
        FL_TXERR  = 3'd3,
        FL_LINE   = 3'd4
    } flag_e;

    // Live status field positions
    localparam int unsigned S_RXEMPTY = 5;
    localparam int unsigned S_TXFULL  = 6;
    localparam int unsigned S_CTS     = 7;
    localparam int unsigned S_RTS     = 8;
    localparam int unsigned S_TXIDLE  = 10;
    localparam int unsigned S_LVL_LO  = 11;
    localparam int unsigned S_BUSY    = 17;
endpackage

// File: rtl/uart_regif_fifo.sv
// Module: synchronous byte FIFO with occupancy count.
// Assumes DEPTH >= 2. A push on a full FIFO is accepted only when a pop
// happens in the same cycle; otherwise it is rejected and flagged on drop.
// A pop on an empty FIFO is ignored.
module uart_regif_fifo #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned WIDTH = 8,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full,
    output logic [CNT_W-1:0] count,
    output logic             drop
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    // Accept rules for the two ports
    always_comb begin
        do_pop  = pop && !empty;
        do_push = push && (!full || do_pop);
        drop    = push && !do_push;
    end

    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));
    assign head  = mem[rd_ptr];

    // Storage write
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_PUSHPOP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !empty) |=> $stable(count)); // R12
    AST_DROP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (drop && !pop) |=> (count == CNT_W'(DEPTH))); // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH)); // R7
endmodule

// File: rtl/uart_regif_flags.sv
// Module: pending and error flags with write-one-to-clear, plus the
// interrupt line. Assumes clear requests are already qualified by a status
// write. A flag whose source is active in a cycle stays set, so a clear
// takes effect only once its condition has gone.
module uart_regif_flags
    import uart_regif_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_cond,
    input  logic             tx_cond,
    input  logic             set_ovr,
    input  logic             set_txerr,
    input  logic             set_line,
    input  logic [NFLAG-1:0] clr,
    input  logic             rx_ie,
    input  logic             tx_ie,
    output logic [NFLAG-1:0] flags,
    output logic             irq
);
    logic [NFLAG-1:0] src;

    // Gather the set sources by slot
    always_comb begin
        src            = '0;
        src[FL_RXPEND] = rx_cond;
        src[FL_TXPEND] = tx_cond;
        src[FL_OVR]    = set_ovr;
        src[FL_TXERR]  = set_txerr;
        src[FL_LINE]   = set_line;
    end

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        // One sticky flag: set beats clear
        always_ff @(posedge clk) begin
            if (!rst_n) flags[i] <= 1'b0;
            else        flags[i] <= src[i] | (flags[i] & ~clr[i]);
        end
    end

    // Level interrupt from enabled pending flags
    assign irq = (flags[FL_RXPEND] & rx_ie) | (flags[FL_TXPEND] & tx_ie);

    AST_RXPEND_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_cond |=> flags[FL_RXPEND]); // R8
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        set_ovr |=> flags[FL_OVR]); // R7
    AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr == '0) |=> ((flags & $past(flags)) == $past(flags))); // R8
endmodule

// File: rtl/uart_regif.sv
// Module: register front end of a serial port. Decodes four word registers,
// owns both byte FIFOs, the sticky flags and the interrupt line, and drives
// the handshakes toward the frame engine. Assumes single-cycle bus strobes
// with combinational read data and an address that is a byte offset.
module uart_regif
    import uart_regif_pkg::*;
#(
    parameter int unsigned TX_DEPTH = 16,
    parameter int unsigned RX_DEPTH = 16,
    parameter int unsigned ADDR_W   = 12,
    localparam int unsigned TX_CW   = $clog2(TX_DEPTH + 1),
    localparam int unsigned RX_CW   = $clog2(RX_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic [7:0]        tx_byte,
    output logic              tx_ready,
    input  logic              tx_pop,
    input  logic              tx_busy,
    input  logic [7:0]        rx_byte,
    input  logic              rx_push,
    input  logic              rx_line_err,
    input  logic              cts_in,
    output logic              rts_out,
    output logic              loopback_en,
    output logic              rx_dma_req,
    output logic              tx_dma_req
);
    logic [WORD_W-1:0] ctl_q;
    logic              sel_ctrl, sel_rxd, sel_txd, sel_stat;
    logic              port_on;
    logic [BYTE_W-1:0] rx_head;
    logic              tx_empty, tx_full, tx_drop;
    logic              rx_empty, rx_full, rx_drop;
    logic [TX_CW-1:0]  tx_cnt;
    logic [RX_CW-1:0]  rx_cnt;
    logic              rx_pop_bus, tx_push_bus, rx_push_eng, tx_pop_eng;
    logic [NFLAG-1:0]  flags, clr;
    logic              tx_low;
    logic [LVL_W-1:0]  lvl;
    logic [WORD_W-1:0] stat_word;

    // Address decode for the four registers
    always_comb begin
        sel_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
        sel_rxd  = (bus_addr == ADDR_W'(OFS_RXD));
        sel_txd  = (bus_addr == ADDR_W'(OFS_TXD));
        sel_stat = (bus_addr == ADDR_W'(OFS_STAT));
    end

    // Control register with only the defined bits kept
    always_ff @(posedge clk) begin
        if (!rst_n)                  ctl_q <= '0;
        else if (bus_wr && sel_ctrl) ctl_q <= bus_wdata & CTRL_KEEP;
    end

    assign port_on = ctl_q[C_EN];

    // Handshake qualification on both sides
    always_comb begin
        rx_pop_bus  = bus_rd && sel_rxd;
        tx_push_bus = bus_wr && sel_txd;
        rx_push_eng = rx_push && port_on;
        tx_pop_eng  = tx_pop && tx_ready;
    end

    uart_regif_fifo #(.DEPTH(TX_DEPTH), .WIDTH(BYTE_W)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (tx_push_bus),
        .din   (bus_wdata[BYTE_W-1:0]),
        .pop   (tx_pop_eng),
        .head  (tx_byte),
        .empty (tx_empty),
        .full  (tx_full),
        .count (tx_cnt),
        .drop  (tx_drop)
    );

    uart_regif_fifo #(.DEPTH(RX_DEPTH), .WIDTH(BYTE_W)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_push_eng),
        .din   (rx_byte),
        .pop   (rx_pop_bus),
        .head  (rx_head),
        .empty (rx_empty),
        .full  (rx_full),
        .count (rx_cnt),
        .drop  (rx_drop)
    );

    // Transmit refill condition and status clear mask
    always_comb begin
        tx_low = (int'(tx_cnt) <= int'(TX_DEPTH / 2));
        clr    = (bus_wr && sel_stat) ? bus_wdata[NFLAG-1:0] : '0;
    end

    uart_regif_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_cond   (!rx_empty),
        .tx_cond   (tx_low),
        .set_ovr   (rx_drop),
        .set_txerr (tx_drop),
        .set_line  (rx_line_err && port_on),
        .clr       (clr),
        .rx_ie     (ctl_q[C_RXIE]),
        .tx_ie     (ctl_q[C_TXIE]),
        .flags     (flags),
        .irq       (irq)
    );

    // Engine and modem side outputs
    always_comb begin
        tx_ready    = port_on && !tx_empty && (!ctl_q[C_FLOW] || cts_in);
        rts_out     = port_on && (!ctl_q[C_FLOW] || !rx_full);
        loopback_en = ctl_q[C_LOOP];
        rx_dma_req  = ctl_q[C_RXDMA] && !rx_empty;
        tx_dma_req  = ctl_q[C_TXDMA] && !tx_full;
    end

    // Status word assembly with the selectable level field
    always_comb begin
        lvl = ctl_q[C_LVLTX] ? LVL_W'(tx_cnt) : LVL_W'(rx_cnt);
        stat_word                            = '0;
        stat_word[NFLAG-1:0]                 = flags;
        stat_word[S_RXEMPTY]                 = rx_empty;
        stat_word[S_TXFULL]                  = tx_full;
        stat_word[S_CTS]                     = cts_in;
        stat_word[S_RTS]                     = rts_out;
        stat_word[S_TXIDLE]                  = tx_empty && !tx_busy;
        stat_word[S_LVL_LO+LVL_W-1:S_LVL_LO] = lvl;
        stat_word[S_BUSY]                    = tx_busy;
    end

    // Read data mux
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (sel_ctrl)                 bus_rdata = ctl_q;
            else if (sel_rxd && !rx_empty) bus_rdata = {24'd0, rx_head};
            else if (sel_stat)            bus_rdata = stat_word;
        end
    end

    AST_RXREAD_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop_bus && rx_empty) |-> (bus_rdata == '0)); // R4
    AST_CTS_HOLDS_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[C_FLOW] && !cts_in) |-> !tx_ready); // R10
    AST_DISABLED_NO_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (!port_on && !rx_pop_bus) |=> $stable(rx_cnt)); // R7
    AST_TXPOP_ONLY_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_ready && !tx_push_bus) |=> $stable(tx_cnt)); // R3
endmodule

// File: tb/tb_uart_regif.sv
module tb_uart_regif;
    localparam int AW = 12;
    localparam logic [AW-1:0] A_CTRL = 12'h000, A_RXD = 12'h004,
                              A_TXD = 12'h008, A_STAT = 12'h00C;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_wr = 0, bus_rd = 0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic irq, tx_ready, rts_out, loopback_en, rx_dma_req, tx_dma_req;
    logic [7:0] tx_byte, rx_byte = '0;
    logic tx_pop = 0, tx_busy = 0, rx_push = 0, rx_line_err = 0, cts_in = 0;
    int checks = 0, fails = 0;
    logic [31:0] rd;
    logic [7:0] b;

    always #5 clk = ~clk;

    uart_regif dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .tx_byte(tx_byte), .tx_ready(tx_ready), .tx_pop(tx_pop),
        .tx_busy(tx_busy), .rx_byte(rx_byte), .rx_push(rx_push),
        .rx_line_err(rx_line_err), .cts_in(cts_in), .rts_out(rts_out),
        .loopback_en(loopback_en), .rx_dma_req(rx_dma_req),
        .tx_dma_req(tx_dma_req)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1 bus_wr = 0;
    endtask

    task automatic rdw(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk); bus_rd = 1; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1 bus_rd = 0;
    endtask

    task automatic push(input logic [7:0] v);
        @(negedge clk); rx_push = 1; rx_byte = v;
        @(posedge clk); #1 rx_push = 0;
    endtask

    task automatic pop(output logic [7:0] v);
        @(negedge clk); v = tx_byte; tx_pop = 1;
        @(posedge clk); #1 tx_pop = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic logic [31:0] lvl(input logic [31:0] s);
        return (s >> 11) & 32'h3F;
    endfunction

    task automatic t_reset;
        rdw(A_STAT, rd); chk("R1 status", rd, 32'h422);
        rdw(A_CTRL, rd); chk("R1 ctrl", rd, 32'h0);
        chk("R1 irq", irq, 0); chk("R1 rts", rts_out, 0);
    endtask

    task automatic t_ctrl;
        wr(A_CTRL, 32'hFFFF_FFFF);
        rdw(A_CTRL, rd); chk("R2 ctrl mask", rd, 32'h001F_D000);
        chk("R11 loopback", loopback_en, 1);
        wr(A_CTRL, 32'h0);
    endtask

    task automatic t_tx;
        wr(A_CTRL, 32'hC000);
        wr(A_TXD, 32'h1234_56A5); wr(A_TXD, 32'hFFFF_FF3C); wr(A_TXD, 32'h0F);
        rdw(A_STAT, rd);
        chk("R5 tx level", lvl(rd), 3); chk("R5 txidle low", rd[10], 0);
        chk("R3 ready", tx_ready, 1);
        pop(b); chk("R3 byte0", b, 8'hA5);
        pop(b); chk("R3 byte1", b, 8'h3C);
        pop(b); chk("R3 byte2", b, 8'h0F);
        chk("R3 ready drained", tx_ready, 0);
        tx_busy = 1;
        rdw(A_STAT, rd); chk("R5 busy bit", rd[17], 1); chk("R5 idle while busy", rd[10], 0);
        tx_busy = 0;
        rdw(A_STAT, rd); chk("R5 idle", rd[10], 1);
    endtask

    task automatic t_flow;
        wr(A_CTRL, 32'h9000); cts_in = 0;
        wr(A_TXD, 32'h55);
        chk("R10 held by cts", tx_ready, 0);
        rdw(A_STAT, rd); chk("R10 cts bit", rd[7], 0); chk("R10 rts bit", rd[8], 1);
        cts_in = 1; #1;
        chk("R10 released", tx_ready, 1);
        rdw(A_STAT, rd); chk("R10 cts bit hi", rd[7], 1);
        pop(b); chk("R10 byte", b, 8'h55);
        cts_in = 0;
    endtask

    task automatic t_rx;
        wr(A_CTRL, 32'h8000);
        push(8'h11); push(8'h22); idle(1);
        rdw(A_STAT, rd);
        chk("R5 rx not empty", rd[5], 0); chk("R5 rx level", lvl(rd), 2);
        chk("R8 rx pend", rd[0], 1);
        wr(A_STAT, 32'h1);
        rdw(A_STAT, rd); chk("R8 clear refused", rd[0], 1);
        rdw(A_RXD, rd); chk("R4 first", rd, 32'h11);
        rdw(A_RXD, rd); chk("R4 second", rd, 32'h22);
        rdw(A_RXD, rd); chk("R4 empty read", rd, 32'h0);
        wr(A_STAT, 32'h0);
        rdw(A_STAT, rd); chk("R8 zero write keeps", rd[0], 1);
        wr(A_STAT, 32'h1);
        rdw(A_STAT, rd); chk("R8 clear ok", rd[0], 0);
    endtask

    task automatic t_ovr;
        wr(A_CTRL, 32'h9000);
        for (int i = 0; i < 17; i++) push(8'(8'h40 + i));
        idle(1);
        rdw(A_STAT, rd);
        chk("R7 overrun", rd[2], 1); chk("R7 level full", lvl(rd), 16);
        chk("R10 rts full", rts_out, 0);
        for (int i = 0; i < 16; i++) begin
            rdw(A_RXD, rd); chk("R7 kept data", rd, 32'(8'h40 + i));
        end
        wr(A_STAT, 32'h4);
        rdw(A_STAT, rd); chk("R7 ovr cleared", rd[2], 0);
        @(negedge clk); rx_line_err = 1; @(posedge clk); #1 rx_line_err = 0;
        rdw(A_STAT, rd); chk("R7 line err", rd[4], 1);
        wr(A_STAT, 32'h10);
        rdw(A_STAT, rd); chk("R7 line cleared", rd[4], 0);
        wr(A_CTRL, 32'h0);
        push(8'h99);
        @(negedge clk); rx_line_err = 1; @(posedge clk); #1 rx_line_err = 0;
        wr(A_CTRL, 32'h8000);
        rdw(A_STAT, rd);
        chk("R7 disabled push ignored", lvl(rd), 0); chk("R7 disabled empty", rd[5], 1);
        chk("R7 disabled line ignored", rd[4], 0);
    endtask

    task automatic t_txfull;
        wr(A_CTRL, 32'hC000);
        for (int i = 0; i < 17; i++) wr(A_TXD, 32'(8'h60 + i));
        rdw(A_STAT, rd);
        chk("R6 full bit", rd[6], 1); chk("R6 tx error", rd[3], 1);
        chk("R6 level", lvl(rd), 16);
        wr(A_STAT, 32'hA);
        rdw(A_STAT, rd); chk("R8 tx pend cleared", rd[1], 0); chk("R6 err cleared", rd[3], 0);
        for (int i = 0; i < 8; i++) begin
            pop(b); chk("R6 order", b, 8'(8'h60 + i));
        end
        idle(1);
        rdw(A_STAT, rd); chk("R8 tx pend half", rd[1], 1);
        for (int i = 8; i < 16; i++) begin
            pop(b); chk("R6 order", b, 8'(8'h60 + i));
        end
        chk("R6 dropped not sent", tx_ready, 0);
    endtask

    task automatic t_irq;
        wr(A_CTRL, 32'h88000); idle(1);
        chk("R9 tx irq", irq, 1);
        wr(A_CTRL, 32'h8000); wr(A_STAT, 32'h1);
        chk("R9 no enable", irq, 0);
        wr(A_CTRL, 32'h48000);
        chk("R9 rx idle", irq, 0);
        push(8'h5A); idle(1);
        chk("R9 rx irq", irq, 1);
        rdw(A_RXD, rd);
        wr(A_STAT, 32'h1);
        chk("R9 rx irq cleared", irq, 0);
    endtask

    task automatic t_dma;
        wr(A_CTRL, 32'h38000);
        chk("R11 rx dma idle", rx_dma_req, 0); chk("R11 tx dma", tx_dma_req, 1);
        push(8'h01);
        chk("R11 rx dma", rx_dma_req, 1); chk("R11 loop off", loopback_en, 0);
        rdw(A_RXD, rd);
    endtask

    task automatic t_same;
        wr(A_CTRL, 32'h8000); wr(A_STAT, 32'h1F);
        for (int i = 0; i < 16; i++) push(8'(8'h80 + i));
        @(negedge clk); bus_rd = 1; bus_addr = A_RXD; rx_push = 1; rx_byte = 8'hEE;
        #1 rd = bus_rdata;
        @(posedge clk); #1 bus_rd = 0; rx_push = 0;
        chk("R12 read oldest", rd, 32'h80);
        rdw(A_STAT, rd); chk("R12 no overrun", rd[2], 0); chk("R12 level", lvl(rd), 16);
        for (int i = 1; i < 16; i++) begin
            rdw(A_RXD, rd); chk("R12 order", rd, 32'(8'h80 + i));
        end
        rdw(A_RXD, rd); chk("R12 new last", rd, 32'hEE);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        idle(2);
        t_reset; t_ctrl; t_tx; t_flow; t_rx; t_ovr; t_txfull; t_irq; t_dma; t_same;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule